// File: doc/BRIEF.md
# Per-Stream Input Frame Offset Aligner

This block takes a group of serial input streams that arrive with different delays relative to a common frame pulse and produces, for each stream, a bit strobe and the bit sampled at that strobe. The sampling point of every stream can be moved later in steps of one quarter of the internal master clock. The block runs on the quarter-step clock, so one clock cycle is one offset step. Offsets are programmed through 16-bit registers, each of which holds the 4-bit offsets of four neighbouring streams. A new offset takes effect at the next frame pulse, so no frame is ever sampled with a partly applied shift.

The block can also measure a stream's offset. The serial input pin then acts as a frame-evaluation line. When a frame pulse arrives with measurement enabled, each stream counts clock cycles until the first rising edge on its line. It then reports that count and raises a done flag, so software can copy the value into the offset register.

The sampled bits leave the block as a valid-only stream: `samp_valid` is high for one cycle per bit and there is no ready input. The block cannot be back-pressed, so a consumer must take every bit in the cycle it is offered. All other pins are plain control and status signals.

Top module: `frame_offset_aligner`

## Requirements
- R1: While reset is held and after reset until the first frame pulse, `samp_valid` stays 0, `meas_done` is 0, `meas_count` is 0 and every active offset is 0.
- R2: A write with `cfg_we` high and `cfg_addr` = r loads bits [4f+3:4f] of `cfg_wdata` as the pending offset of stream 4r+f, for f = 0..3; other registers are unchanged.
- R3: Pending offsets become active only at the clock edge where `frame_pulse` is sampled high; a write in the middle of a frame leaves that frame's strobes unchanged.
- R4: Let T be the number of edges since the frame-pulse edge, minus one, so T is 0 at the first edge after the pulse. For active offset o, stream s samples `ser_in[s]` at the edge where T = o + 8b + 4, for b = 0..15. In the next cycle `samp_valid[s]` is 1 and `samp_bit[s]` holds the sampled value.
- R5: A stream produces exactly 16 strobes per frame, 8 cycles apart, and none outside that window.
- R6: A frame pulse sampled with `meas_en` high arms measurement on every stream. If the first rising edge of `ser_in[s]` is sampled n edges after the pulse edge, with 1 ≤ n ≤ 15, then from the next cycle `meas_count[s]` = n and `meas_done[s]` = 1, both holding until the next armed pulse.
- R7: A stream that shows no rising edge within 15 edges after an armed pulse stops measuring and keeps `meas_done[s]` at 0.
- R8: A frame pulse with `meas_en` high clears `meas_done` for every stream in the following cycle.
- R9: Each stream's strobes and measurement depend only on its own offset and its own input.
- R10: `samp_valid[s]` is never high in two consecutive cycles; the output has no ready signal and no back-pressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Quarter-step clock (four cycles per master clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_pulse | input | 1 | One-cycle frame start marker |
| meas_en | input | 1 | Arms offset measurement at a frame pulse |
| cfg_we | input | 1 | Offset register write strobe |
| cfg_addr | input | 1 | Offset register index |
| cfg_wdata | input | 16 | Four packed 4-bit offsets |
| ser_in | input | 8 | Serial data / frame-evaluation line per stream |
| samp_valid | output | 8 | Per-stream bit strobe (valid only) |
| samp_bit | output | 8 | Per-stream sampled bit |
| meas_done | output | 8 | Measurement completed per stream |
| meas_count | output | 32 | Measured offset, 4 bits per stream |

## Verification
A sampled bit appears on `samp_valid`/`samp_bit` one cycle after the edge that captured it. A measured count and its done flag appear one cycle after the edge that sees the rising input. An offset write changes the strobes only from the edge that samples the next frame pulse. The bench keeps its own edge-by-edge model of the tick count, the pending and active offsets and the measurement counters. It updates that model with the inputs each edge sampled, then compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. Data are driven at the programmed delay and checked against the known bit patterns. Measurement frames use a different rise time per stream and are checked for the exact count.

// File: rtl/ofs_align_pkg.sv
package ofs_align_pkg;
  typedef enum logic {
    MS_IDLE  = 1'b0,
    MS_ARMED = 1'b1
  } meas_state_e;
endpackage

// File: rtl/ofs_regfile.sv
module ofs_regfile #(
  parameter int NUM_STREAMS = 8,
  parameter int OFS_W       = 4,
  parameter int FPR         = 4,
  parameter int REG_W       = 16,
  parameter int AW          = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_pulse,
  input  logic                         cfg_we,
  input  logic [AW-1:0]                cfg_addr,
  input  logic [REG_W-1:0]             cfg_wdata,
  output logic [NUM_STREAMS*OFS_W-1:0] act_ofs
);
  logic [NUM_STREAMS*OFS_W-1:0] pend_ofs;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_fld
    localparam int RI = s / FPR;
    localparam int FI = s % FPR;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_ofs[s*OFS_W +: OFS_W] <= '0;
        act_ofs[s*OFS_W +: OFS_W]  <= '0;
      end else begin
        if (frame_pulse)
          act_ofs[s*OFS_W +: OFS_W] <= pend_ofs[s*OFS_W +: OFS_W];
        if (cfg_we && cfg_addr == AW'(RI))
          pend_ofs[s*OFS_W +: OFS_W] <= cfg_wdata[FI*OFS_W +: OFS_W];
      end
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse |=> $stable(act_ofs)); // R3
endmodule

// File: rtl/ofs_frame_timer.sv
module ofs_frame_timer #(
  parameter int TCW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_pulse,
  output logic           started,
  output logic [TCW-1:0] tcnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      tcnt    <= '0;
    end else if (frame_pulse) begin
      started <= 1'b1;
      tcnt    <= '0;
    end else if (tcnt != '1) begin
      tcnt <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/ofs_lane.sv
module ofs_lane
  import ofs_align_pkg::*;
#(
  parameter int OFS_W       = 4,
  parameter int TCW         = 9,
  parameter int FRAME_TICKS = 128,
  parameter int TPB_LOG     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  input  logic             meas_en,
  input  logic             started,
  input  logic [TCW-1:0]   tcnt,
  input  logic [OFS_W-1:0] ofs,
  input  logic             ser,
  output logic             out_valid,
  output logic             out_bit,
  output logic             done,
  output logic [OFS_W-1:0] value
);
  localparam logic [TCW-1:0]     FT_V  = TCW'(FRAME_TICKS);
  localparam logic [TPB_LOG-1:0] PH_V  = TPB_LOG'((1 << TPB_LOG) / 2);
  localparam logic [OFS_W-1:0]   CMAX  = '1;

  logic [TCW-1:0] ofs_ext, diff;
  logic           strobe;
  meas_state_e    mstate;
  logic [OFS_W-1:0] mcnt;
  logic           prev;

  assign ofs_ext = TCW'(ofs);
  assign diff    = tcnt - ofs_ext;
  assign strobe  = started && (tcnt >= ofs_ext) && (diff < FT_V) &&
                   (diff[TPB_LOG-1:0] == PH_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= strobe;
      if (strobe) out_bit <= ser;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstate <= MS_IDLE;
      mcnt   <= '0;
      done   <= 1'b0;
      value  <= '0;
      prev   <= 1'b0;
    end else begin
      prev <= ser;
      if (frame_pulse && meas_en) begin
        mstate <= MS_ARMED;
        mcnt   <= OFS_W'(1);
        done   <= 1'b0;
      end else if (mstate == MS_ARMED) begin
        if (ser && !prev) begin
          value  <= mcnt;
          done   <= 1'b1;
          mstate <= MS_IDLE;
        end else if (mcnt == CMAX) begin
          mstate <= MS_IDLE;
        end else begin
          mcnt <= mcnt + 1'b1;
        end
      end
    end
  end

  AST_NO_STROBE_UNSTARTED: assert property (@(posedge clk) disable iff (!rst_n)
    !started |=> !out_valid); // R1
  AST_SINGLE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R10
  AST_DONE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> value != '0); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(frame_pulse && meas_en) |=> done); // R6
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse && meas_en |=> !done); // R8
endmodule

// File: rtl/frame_offset_aligner.sv
module frame_offset_aligner #(
  parameter int NUM_STREAMS   = 8,
  parameter int OFS_W         = 4,
  parameter int REG_W         = 16,
  parameter int TICKS_PER_BIT = 8,
  parameter int FRAME_BITS    = 16,
  localparam int FPR          = REG_W / OFS_W,
  localparam int NUM_REGS     = (NUM_STREAMS + FPR - 1) / FPR,
  localparam int AW           = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_pulse,
  input  logic                         meas_en,
  input  logic                         cfg_we,
  input  logic [AW-1:0]                cfg_addr,
  input  logic [REG_W-1:0]             cfg_wdata,
  input  logic [NUM_STREAMS-1:0]       ser_in,
  output logic [NUM_STREAMS-1:0]       samp_valid,
  output logic [NUM_STREAMS-1:0]       samp_bit,
  output logic [NUM_STREAMS-1:0]       meas_done,
  output logic [NUM_STREAMS*OFS_W-1:0] meas_count
);
  localparam int TPB_LOG     = $clog2(TICKS_PER_BIT);
  localparam int FRAME_TICKS = TICKS_PER_BIT * FRAME_BITS;
  localparam int TCW         = $clog2(FRAME_TICKS + (1 << OFS_W)) + 1;

  logic [NUM_STREAMS*OFS_W-1:0] act_ofs;
  logic                         started;
  logic [TCW-1:0]               tcnt;

  ofs_regfile #(
    .NUM_STREAMS(NUM_STREAMS), .OFS_W(OFS_W), .FPR(FPR),
    .REG_W(REG_W), .AW(AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .act_ofs(act_ofs)
  );

  ofs_frame_timer #(.TCW(TCW)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .started(started), .tcnt(tcnt)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
    ofs_lane #(
      .OFS_W(OFS_W), .TCW(TCW), .FRAME_TICKS(FRAME_TICKS), .TPB_LOG(TPB_LOG)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .meas_en(meas_en),
      .started(started), .tcnt(tcnt), .ofs(act_ofs[s*OFS_W +: OFS_W]),
      .ser(ser_in[s]), .out_valid(samp_valid[s]), .out_bit(samp_bit[s]),
      .done(meas_done[s]), .value(meas_count[s*OFS_W +: OFS_W])
    );
  end
endmodule

// File: tb/frame_offset_aligner_test.sv
module frame_offset_aligner_test;
  localparam int N  = 8;
  localparam int OW = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            frame_pulse, meas_en, cfg_we;
  logic [0:0]      cfg_addr;
  logic [15:0]     cfg_wdata;
  logic [N-1:0]    ser_in;
  logic [N-1:0]    samp_valid, samp_bit, meas_done;
  logic [N*OW-1:0] meas_count;

  always #5 clk = ~clk;

  frame_offset_aligner uut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .meas_en(meas_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ser_in(ser_in), .samp_valid(samp_valid), .samp_bit(samp_bit),
    .meas_done(meas_done), .meas_count(meas_count)
  );

  int checks = 0;
  int errors = 0;

  // bench model state
  int m_j = 0;
  bit m_started = 0;
  int m_act[N];
  int m_pend[N];
  bit m_ov[N];
  bit m_ob[N];
  bit m_pb[N];
  bit m_pchk[N];
  bit m_arm[N];
  int m_cnt[N];
  bit m_done[N];
  int m_val[N];
  bit m_prev[N];

  int  mode = 2;        // 0 data, 1 measurement, 2 idle toggling
  bit  nx_fp = 0, nx_meas = 0, nx_wr = 0;
  int  nx_addr = 0;
  logic [15:0] nx_data = '0;
  int  rise[N] = '{1, 2, 5, 8, 11, 15, 3, 99};
  bit  tog = 0;

  function automatic logic [15:0] pat(input int s);
    return 16'hB4E1 ^ 16'(16'h02F5 * (s + 1));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    // model update with the inputs sampled at the edge just past
    for (int s = 0; s < N; s++) begin
      int d;
      d = m_j - m_act[s];
      m_ov[s] = m_started && d >= 0 && d < 128 && (d % 8) == 4;   // R4 R5
      if (m_ov[s]) begin
        m_ob[s]   = ser_in[s];
        m_pb[s]   = pat(s)[d / 8];
        m_pchk[s] = (mode == 0);
      end
      if (frame_pulse && meas_en) begin
        m_arm[s] = 1; m_cnt[s] = 1; m_done[s] = 0;
      end else if (m_arm[s]) begin
        if (ser_in[s] && !m_prev[s]) begin
          m_val[s] = m_cnt[s]; m_done[s] = 1; m_arm[s] = 0;
        end else if (m_cnt[s] == 15) m_arm[s] = 0;
        else m_cnt[s]++;
      end
      m_prev[s] = ser_in[s];
    end
    if (frame_pulse) begin
      for (int s = 0; s < N; s++) m_act[s] = m_pend[s];   // R3
      m_j = 0; m_started = 1;
    end else if (m_j < 255) m_j++;
    if (cfg_we)   // R2: register r field f -> stream 4r+f
      for (int f = 0; f < 4; f++) m_pend[int'(cfg_addr) * 4 + f] = int'(cfg_wdata[f*4 +: 4]);
    // compare
    for (int s = 0; s < N; s++) begin
      check(samp_valid[s] == m_ov[s], $sformatf("R4/R5/R3/R2 valid s%0d", s),
            int'(samp_valid[s]), int'(m_ov[s]));
      if (m_ov[s]) begin
        check(samp_bit[s] == m_ob[s], $sformatf("R4 bit s%0d", s),
              int'(samp_bit[s]), int'(m_ob[s]));
        if (m_pchk[s])   // R9: each stream carries its own pattern
          check(samp_bit[s] == m_pb[s], $sformatf("R4/R9 pattern s%0d", s),
                int'(samp_bit[s]), int'(m_pb[s]));
      end
      check(meas_done[s] == m_done[s], $sformatf("R6/R7/R8 done s%0d", s),
            int'(meas_done[s]), int'(m_done[s]));
      check(int'(meas_count[s*OW +: OW]) == m_val[s], $sformatf("R6 count s%0d", s),
            int'(meas_count[s*OW +: OW]), m_val[s]);
    end
    // drive next inputs
    frame_pulse = nx_fp;
    meas_en     = nx_meas;
    cfg_we      = nx_wr;
    cfg_addr    = 1'(nx_addr);
    cfg_wdata   = nx_data;
    tog = ~tog;
    for (int s = 0; s < N; s++) begin
      int d;
      d = m_j - m_act[s];
      if (nx_fp) ser_in[s] = 1'b0;
      else if (mode == 0) ser_in[s] = (m_started && d >= 0 && d < 128) ? pat(s)[d / 8] : 1'b0;
      else if (mode == 1) ser_in[s] = (m_j + 1 >= rise[s]);
      else ser_in[s] = tog ^ s[0];
    end
    nx_fp = 0; nx_meas = 0; nx_wr = 0;
  endtask

  task automatic write_reg(input int addr, input logic [15:0] data);
    nx_wr = 1; nx_addr = addr; nx_data = data;   // R2
    step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int s = 0; s < N; s++) begin
      m_act[s] = 0; m_pend[s] = 0; m_ov[s] = 0; m_ob[s] = 0; m_pb[s] = 0;
      m_pchk[s] = 0; m_arm[s] = 0; m_cnt[s] = 0; m_done[s] = 0; m_val[s] = 0; m_prev[s] = 0;
    end
    rst_n = 1'b0; frame_pulse = 0; meas_en = 0; cfg_we = 0; cfg_addr = '0;
    cfg_wdata = '0; ser_in = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(samp_valid == '0, "R1 reset valid", int'(samp_valid), 0);
    check(meas_done == '0, "R1 reset done", int'(meas_done), 0);
    check(meas_count == '0, "R1 reset count", int'(meas_count), 0);
    rst_n = 1'b1;
    // R1: toggling input before any frame pulse gives no strobe
    repeat (20) step();
    // R2: program stream offsets 3,0,7,15 and 1,5,10,12
    write_reg(0, {4'd15, 4'd7, 4'd0, 4'd3});
    write_reg(1, {4'd12, 4'd10, 4'd5, 4'd1});
    mode = 0;
    nx_fp = 1; step();
    repeat (179) step();
    nx_fp = 1; step();
    repeat (59) step();
    // R3: mid-frame rewrite must not move this frame's strobes
    write_reg(0, {4'd2, 4'd9, 4'd4, 4'd6});
    repeat (118) step();
    nx_fp = 1; step();
    repeat (179) step();
    // R6/R7: measurement frame with per-stream rise times
    mode = 1;
    nx_fp = 1; nx_meas = 1; step();
    repeat (25) step();
    for (int s = 0; s < N; s++) begin
      bit ed;
      ed = (rise[s] <= 15);
      check(meas_done[s] == ed, $sformatf("R6/R7 measured done s%0d", s), int'(meas_done[s]), int'(ed));
      if (ed)
        check(int'(meas_count[s*OW +: OW]) == rise[s], $sformatf("R6 measured offset s%0d", s),
              int'(meas_count[s*OW +: OW]), rise[s]);
    end
    // R8: a new armed pulse clears every done flag
    nx_fp = 1; nx_meas = 1; step();
    step();
    check(meas_done == '0, "R8 done cleared", int'(meas_done), 0);
    repeat (25) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule